// File: doc/BRIEF.md
# Boot Sector Write-Protection Guard

This block sits next to the command engine of a small flash array. It divides an 18-bit byte address space into five sectors of unequal size, with the boot sector at the bottom. It also holds a sticky boot-lock flag. For each request from the engine, the block works out which sector is addressed. It then states whether a byte program, a sector erase or a chip erase may proceed. For chip erase it gives a mask of the sectors that may be cleared.

The lock flag is set by a one-cycle pulse from the command engine once the lock command sequence has finished. Neither reset nor any erase clears it. A high-voltage override input lifts the protection for as long as it is held. A supply-low input refuses every modifying operation. In identification mode, one status address returns the lock state in bit 0. All results are registered one cycle after the request, so the engine always samples stable values.

Top module: `bootlock_guard`

## Requirements
- R1: With `op_valid` high at a rising edge, `rsp_valid` is high after that edge and `sector_idx` gives the sector of `addr`: 0 for 0x00000..0x03FFF, 1 for 0x04000..0x05FFF, 2 for 0x06000..0x07FFF, 3 for 0x08000..0x1FFFF, and 4 for 0x20000..0x3FFFF.
- R2: `op` encodes 0 = byte program, 1 = sector erase, 2 = chip erase, 3 = identification read. When unlocked and the supply is good, `prog_ok` (op 0) or `serase_ok` (op 1) is 1 for every sector. Each permit stays 0 for any other op.
- R3: When locked and no override is present, program and sector erase aimed at sector 0 return a permit of 0. The same operations on sectors 1 to 4 still return 1.
- R4: For chip erase, `cerase_ok` is 1 and `erase_mask` bit i stands for sector i. The mask is 5'b11111 when unlocked and 5'b11110 when locked. It is 0 for every op other than chip erase.
- R5: While `hv_override` is high, sector 0 is treated as unlocked for program, sector erase and chip erase. Once the override drops, the lock applies again.
- R6: While `supply_low` is high, every permit and the mask are 0, and a `lock_set` pulse has no effect.
- R7: A `lock_set` pulse with the supply good sets the lock. Neither reset nor any erase clears it.
- R8: An identification read (op 3) at address 0x00002 returns `id_byte` = {7'b0, lock}. Any other address or op returns 0.
- R9: A request in the same cycle as a `lock_set` pulse is judged against the lock state from before the pulse.
- R10: Synchronous reset, and any cycle with `op_valid` low, leave every output at 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (outputs only) |
| op_valid | input | 1 | A request is present this cycle |
| op | input | 2 | Operation code (see R2) |
| addr | input | 18 | Byte address of the request |
| lock_set | input | 1 | Pulse: lock command completed |
| hv_override | input | 1 | High-voltage override present |
| supply_low | input | 1 | Supply below the programming threshold |
| rsp_valid | output | 1 | Registered results are valid |
| sector_idx | output | 3 | Sector index of the request |
| prog_ok | output | 1 | Byte program permitted |
| serase_ok | output | 1 | Sector erase permitted |
| cerase_ok | output | 1 | Chip erase permitted |
| erase_mask | output | 5 | Sectors cleared by chip erase |
| id_byte | output | 8 | Identification read data |

## Verification
A lock pulse and a request can fall in the same cycle. The bench provokes this by raising `lock_set` together with a program request to the boot sector. It expects that request to be permitted, because the old lock state applies. It then expects the following identification read to return 1. The supply-low input can also coincide with a lock pulse. That pairing is judged afterwards through an identification read that must still report 0. Address sweeps cover every sector boundary on both sides, in the unlocked, locked and override states.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_IDREAD = 2'd3
  } op_e;

  localparam int NSECT  = 5;
  localparam int SECT_W = $clog2(NSECT);
endpackage

// File: rtl/sector_map.sv
module sector_map
  import bootlock_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int PARAM1_BASE = 'h04000,
  parameter int PARAM2_BASE = 'h06000,
  parameter int MAIN1_BASE  = 'h08000,
  parameter int MAIN2_BASE  = 'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SECT_W-1:0] idx,
  output logic              is_boot
);
  localparam int NB = NSECT - 1;
  localparam logic [ADDR_W-1:0] BASES [NB] = '{
    ADDR_W'(PARAM1_BASE), ADDR_W'(PARAM2_BASE),
    ADDR_W'(MAIN1_BASE),  ADDR_W'(MAIN2_BASE)
  };

  logic [NB-1:0] above;

  // one comparator per sector boundary; bases ascend so the count is the index
  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign above[g] = (addr >= BASES[g]);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NB; i++) begin
      if (above[i]) idx = idx + SECT_W'(1);
    end
  end

  assign is_boot = ~above[0];
endmodule

// File: rtl/lock_register.sv
module lock_register (
  input  logic clk,
  input  logic set_req,
  input  logic supply_low,
  output logic locked
);
  // non-volatile in the real array: no reset term, simulation starts cleared
  logic lock_q = 1'b0;

  always_ff @(posedge clk) begin
    if (set_req && !supply_low) lock_q <= 1'b1;
  end

  assign locked = lock_q;
endmodule

// File: rtl/permit_logic.sv
module permit_logic
  import bootlock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  op_e               op,
  input  logic [SECT_W-1:0] sect,
  input  logic              is_boot,
  input  logic              at_status,
  input  logic              locked,
  input  logic              hv_override,
  input  logic              supply_low,
  output logic              rsp_valid,
  output logic [SECT_W-1:0] sector_idx,
  output logic              prog_ok,
  output logic              serase_ok,
  output logic              cerase_ok,
  output logic [NSECT-1:0]  erase_mask,
  output logic [DATA_W-1:0] id_byte
);
  logic             guard;
  logic             may_touch;
  logic             nx_prog, nx_serase, nx_cerase;
  logic [NSECT-1:0] nx_mask;
  logic [DATA_W-1:0] nx_id;

  assign guard     = locked && !hv_override;
  assign may_touch = op_valid && !supply_low && !(is_boot && guard);

  always_comb begin
    nx_prog   = may_touch && (op == OP_PROG);
    nx_serase = may_touch && (op == OP_SERASE);
    nx_cerase = op_valid && !supply_low && (op == OP_CERASE);
    nx_id     = '0;
    if (op_valid && op == OP_IDREAD && at_status) nx_id[0] = locked;
  end

  // sector 0 is the only one the lock can withhold from a chip erase
  for (genvar s = 0; s < NSECT; s++) begin : g_mask
    if (s == 0) begin : g_boot
      assign nx_mask[s] = nx_cerase && !guard;
    end else begin : g_body
      assign nx_mask[s] = nx_cerase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      sector_idx <= '0;
      prog_ok    <= 1'b0;
      serase_ok  <= 1'b0;
      cerase_ok  <= 1'b0;
      erase_mask <= '0;
      id_byte    <= '0;
    end else begin
      rsp_valid  <= op_valid;
      sector_idx <= op_valid ? sect : '0;
      prog_ok    <= nx_prog;
      serase_ok  <= nx_serase;
      cerase_ok  <= nx_cerase;
      erase_mask <= nx_mask;
      id_byte    <= nx_id;
    end
  end
endmodule

// File: rtl/bootlock_guard.sv
module bootlock_guard
  import bootlock_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int PARAM1_BASE = 'h04000,
  parameter int PARAM2_BASE = 'h06000,
  parameter int MAIN1_BASE  = 'h08000,
  parameter int MAIN2_BASE  = 'h20000,
  parameter int STATUS_ADDR = 'h00002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock_set,
  input  logic              hv_override,
  input  logic              supply_low,
  output logic              rsp_valid,
  output logic [SECT_W-1:0] sector_idx,
  output logic              prog_ok,
  output logic              serase_ok,
  output logic              cerase_ok,
  output logic [NSECT-1:0]  erase_mask,
  output logic [DATA_W-1:0] id_byte
);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

  logic [SECT_W-1:0] sect;
  logic              is_boot;
  logic              locked;
  logic              at_status;
  op_e               op_k;

  assign op_k      = op_e'(op);
  assign at_status = (addr == STATUS_A);

  sector_map #(
    .ADDR_W(ADDR_W), .PARAM1_BASE(PARAM1_BASE), .PARAM2_BASE(PARAM2_BASE),
    .MAIN1_BASE(MAIN1_BASE), .MAIN2_BASE(MAIN2_BASE)
  ) u_map (
    .addr(addr), .idx(sect), .is_boot(is_boot)
  );

  lock_register u_lock (
    .clk(clk), .set_req(lock_set), .supply_low(supply_low), .locked(locked)
  );

  permit_logic #(.DATA_W(DATA_W)) u_permit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op_k), .sect(sect),
    .is_boot(is_boot), .at_status(at_status), .locked(locked),
    .hv_override(hv_override), .supply_low(supply_low),
    .rsp_valid(rsp_valid), .sector_idx(sector_idx), .prog_ok(prog_ok),
    .serase_ok(serase_ok), .cerase_ok(cerase_ok), .erase_mask(erase_mask),
    .id_byte(id_byte)
  );
endmodule

// File: rtl/bootlock_guard_chk.sv
module bootlock_guard_chk
  import bootlock_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int PARAM1_BASE = 'h04000
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [1:0]        op,
  input logic [ADDR_W-1:0] addr,
  input logic              hv_override,
  input logic              supply_low,
  input logic              locked,
  input logic              rsp_valid,
  input logic [SECT_W-1:0] sector_idx,
  input logic              prog_ok,
  input logic              serase_ok,
  input logic              cerase_ok,
  input logic [NSECT-1:0]  erase_mask,
  input logic [DATA_W-1:0] id_byte
);
  localparam logic [ADDR_W-1:0] P1 = ADDR_W'(PARAM1_BASE);

  // R1
  boot_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(addr) < P1) |-> (sector_idx == '0));

  // R3
  boot_prog_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(op_valid && op == 2'd0 && addr < P1 && locked && !hv_override) |-> !prog_ok);

  // R4
  mask_body_chk: assert property (@(posedge clk) disable iff (rst)
    cerase_ok |-> (&erase_mask[NSECT-1:1]));

  // R6
  supply_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(supply_low) |-> (!prog_ok && !serase_ok && !cerase_ok && erase_mask == '0));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> locked);

  // R8
  id_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(op) != 2'd3) |-> (id_byte == '0));
endmodule

bind bootlock_guard bootlock_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARAM1_BASE(PARAM1_BASE)
) u_chk (.*);

// File: tb/test_bootlock_guard.sv
`timescale 1ns/1ps
module test_bootlock_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [17:0] addr = '0;
  logic        lock_set = 1'b0;
  logic        hv_override = 1'b0;
  logic        supply_low = 1'b0;
  logic        rsp_valid;
  logic [2:0]  sector_idx;
  logic        prog_ok, serase_ok, cerase_ok;
  logic [4:0]  erase_mask;
  logic [7:0]  id_byte;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  bit m_lock = 0;

  always #4 clk = ~clk;

  bootlock_guard i_bootlock_guard (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .addr(addr),
    .lock_set(lock_set), .hv_override(hv_override), .supply_low(supply_low),
    .rsp_valid(rsp_valid), .sector_idx(sector_idx), .prog_ok(prog_ok),
    .serase_ok(serase_ok), .cerase_ok(cerase_ok), .erase_mask(erase_mask),
    .id_byte(id_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_sect(input int a);
    if (a < 'h4000) return 0;
    if (a < 'h6000) return 1;
    if (a < 'h8000) return 2;
    if (a < 'h20000) return 3;
    return 4;
  endfunction

  task automatic do_op(input int o, input int a, input bit ls);
    @(negedge clk);
    op_valid = 1'b1; op = 2'(o); addr = 18'(a); lock_set = ls;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; lock_set = 1'b0;
  endtask

  task automatic pulse_lock();
    @(negedge clk); lock_set = 1'b1;
    @(negedge clk); lock_set = 1'b0;
    if (!supply_low) m_lock = 1;
  endtask

  task automatic check_access(input int o, input int a, input string req);
    int  s;
    bit  ok;
    s  = exp_sect(a);
    ok = !supply_low && !(s == 0 && m_lock && !hv_override);
    do_op(o, a, 1'b0);
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " R1 sector"}, sector_idx, s);
    chk({req, " prog_ok"},   prog_ok,   (o == 0) ? ok : 0);
    chk({req, " serase_ok"}, serase_ok, (o == 1) ? ok : 0);
    chk({req, " mask idle R4"}, erase_mask, 0);
  endtask

  task automatic sweep(input string req);
    int edges [9] = '{'h3FFF, 'h4000, 'h5FFF, 'h6000, 'h7FFF,
                      'h8000, 'h1FFFF, 'h20000, 'h3FFFF};
    for (int o = 0; o < 2; o++) begin
      for (int k = 0; k < 64; k++) check_access(o, k * 'h1000, req);
      foreach (edges[e]) check_access(o, edges[e], req);
    end
  endtask

  task automatic check_chip(input string req);
    int m;
    m = supply_low ? 0 : ((m_lock && !hv_override) ? 'h1E : 'h1F);
    do_op(2, 'h12345, 1'b0);
    chk({req, " cerase_ok"}, cerase_ok, supply_low ? 0 : 1);
    chk({req, " erase_mask"}, erase_mask, m);
    chk({req, " prog_ok R2"}, prog_ok, 0);
  endtask

  task automatic check_id(input string req);
    do_op(3, 'h00002, 1'b0);
    chk({req, " id status"}, id_byte, m_lock);
    do_op(3, 'h00003, 1'b0);
    chk({req, " id other addr"}, id_byte, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 mask", erase_mask, 0);
    chk("R10 id", id_byte, 0);
    @(negedge clk); rst = 1'b0;

    // R1 R2: unlocked, full sweep
    sweep("R2 unlocked");
    check_chip("R4 unlocked");
    check_id("R8 unlocked");

    // R10: idle cycle gives zero outputs
    @(negedge clk); @(negedge clk);
    chk("R10 idle rsp_valid", rsp_valid, 0);
    chk("R10 idle sector", sector_idx, 0);

    // R6: supply low refuses everything and blocks a lock pulse
    supply_low = 1'b1;
    check_access(0, 'h10000, "R6 prog");
    check_access(1, 'h00000, "R6 serase");
    check_chip("R6 chip");
    pulse_lock();
    supply_low = 1'b0;
    check_id("R6 lock pulse ignored");

    // R9: lock pulse together with a boot program request
    do_op(0, 'h00100, 1'b1);
    chk("R9 same-cycle prog_ok", prog_ok, 1);
    m_lock = 1;
    check_id("R9 lock now set");

    // R3: locked sweep
    sweep("R3 locked");
    check_chip("R4 locked");

    // R5: override lifts the lock, then it returns
    hv_override = 1'b1;
    check_access(0, 'h00000, "R5 override prog");
    check_access(1, 'h03FFF, "R5 override serase");
    check_chip("R5 override chip");
    hv_override = 1'b0;
    check_access(0, 'h00000, "R5 lock back");
    check_chip("R5 lock back chip");

    // R7: erase and reset leave the lock set
    check_access(1, 'h20000, "R7 erase main");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 reset mask", erase_mask, 0);
    rst = 1'b0;
    check_id("R7 survives reset");
    check_access(1, 'h00002, "R7 boot still refused");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule